// File: doc/BRIEF.md
# Latin-Square Banked Occupancy Grid Store

This block holds a two-dimensional occupancy grid spread over a set of dual-port memory banks. Many compute cores can then fetch cells at the same time. Each cell (x, y) lives in bank `(x + y) mod BANKS`. That bank pattern is a Latin square, repeated over the whole grid. As a result, the cells of one grid row never share a bank within any BANKS-wide stretch, and neither do the cells of one grid column. Cores that walk the same row or column in lock-step therefore spread their requests over distinct banks.

Every bank offers two independent read ports that take an in-bank address and return the cell one cycle later, each with its own valid flag. A single load port writes one cell per cycle from a coordinate and a data word, and routes it to the right bank and address itself. A set of combinational mapping lanes converts core coordinates into the bank and in-bank address that the read ports expect. The arbitration logic that sits in front of the read ports uses these lanes.

Each memory word stores exactly one cell. The in-bank address is `y * (GRID_W / BANKS) + floor(x / BANKS)`.

Top module: `lsq_grid_mem`

## Requirements
- R1: A mapping lane reports bank `(x + y) mod BANKS` for the coordinate (x, y) on its inputs, in the same cycle.
- R2: A mapping lane reports in-bank address `y * (GRID_W / BANKS) + floor(x / BANKS)`, so every cell owns a distinct (bank, address) pair.
- R3: Two cells of one row whose x differ by less than BANKS map to different banks, and likewise for two cells of one column whose y differ by less than BANKS.
- R4: A cycle with the load enable high writes the load data to the bank and address that R1 and R2 give for the load coordinate, and a later read of that location returns it.
- R5: A read port whose enable is high at a clock edge shows the addressed cell and a high valid flag after that edge, one cycle of latency.
- R6: A read port's valid flag is low after reset and after any edge where its enable was low.
- R7: The two read ports of one bank work independently and may read the same or different addresses in the same cycle.
- R8: A read port's data output holds its previous value across any cycle in which that port is not enabled.
- R9: While the load enable is low, the load coordinate and data have no effect on the stored grid.
- R10: The load port and the read ports are never active in the same cycle; loading is a separate phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Load one cell this cycle |
| ld_x | input | XW | Load cell column |
| ld_y | input | YW | Load cell row |
| ld_data | input | CELL_W | Load cell value |
| map_x | input | LANES*XW | Per-lane query column, lane i at bits i*XW |
| map_y | input | LANES*YW | Per-lane query row |
| map_bank | output | LANES*BW | Per-lane bank index |
| map_addr | output | LANES*AW | Per-lane in-bank address |
| rd_en | input | 2*BANKS | Read enable, port p = 2*bank + side |
| rd_addr | input | 2*BANKS*AW | In-bank read address per port |
| rd_data | output | 2*BANKS*CELL_W | Read data per port |
| rd_valid | output | 2*BANKS | Read data valid per port |

## Verification
The assertions assume the caller never raises the load enable in a cycle where any read enable is high. The read behaviour is only defined under that rule, so the checker treats it as an input contract. The row and column bank-separation property is judged only on what mapping lanes 0 and 1 carry, so it depends on the stimulus placing neighbouring cells of one row or column on those two lanes. The bench keeps loads and reads in distinct task calls, each of which drives every input for its cycle. It also feeds lanes 0 and 1 with adjacent cells, and with the wrap-around neighbour at the grid edge.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
   // Read ports offered by every bank (dual-port storage).
   localparam int unsigned PORTS_PER_BANK = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/lsq_addr_map.sv
// Coordinate to (bank, in-bank address) translation.
module lsq_addr_map #(
   parameter int unsigned BANKS  = 16,
   parameter int unsigned GRID_W = 32,
   parameter int unsigned XW     = 5,
   parameter int unsigned YW     = 5,
   parameter int unsigned BW     = 4,
   parameter int unsigned AW     = 6
) (
   input  logic [XW-1:0] cell_x,
   input  logic [YW-1:0] cell_y,
   output logic [BW-1:0] bank,
   output logic [AW-1:0] addr
);
   localparam int unsigned COLS = GRID_W / BANKS;

   generate
      if (lsq_pkg::is_pow2(BANKS)) begin : g_pow2
         // Modulo by a power of two: add only the low bits and let the sum wrap.
         logic [BW-1:0] lo_sum;
         assign lo_sum = cell_x[BW-1:0] + cell_y[BW-1:0];
         assign bank   = lo_sum;
      end else begin : g_mod
         assign bank = BW'((32'(cell_x) + 32'(cell_y)) % BANKS);
      end
   endgenerate

   // Row-major inside a bank: one word per cell, COLS words per grid row.
   assign addr = AW'(32'(cell_y) * COLS + 32'(cell_x) / BANKS);
endmodule

// File: rtl/lsq_bank.sv
// One storage bank: one write port and two registered read ports.
module lsq_bank #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned AW     = 6,
   parameter int unsigned CELL_W = 16,
   parameter int unsigned NRD    = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [AW-1:0]         wr_addr,
   input  logic [CELL_W-1:0]     wr_data,
   input  logic [NRD-1:0]        rd_en,
   input  logic [NRD*AW-1:0]     rd_addr,
   output logic [NRD*CELL_W-1:0] rd_data,
   output logic [NRD-1:0]        rd_valid
);
   logic [CELL_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   generate
      for (genvar s = 0; s < NRD; s++) begin : g_rd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_valid[s]                <= 1'b0;
               rd_data[s*CELL_W +: CELL_W] <= '0;
            end else begin
               rd_valid[s] <= rd_en[s];
               if (rd_en[s]) rd_data[s*CELL_W +: CELL_W] <= mem[rd_addr[s*AW +: AW]];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lsq_grid_mem.sv
// Latin-square banked occupancy grid store (top).
module lsq_grid_mem #(
   parameter int unsigned BANKS  = 16,
   parameter int unsigned GRID_W = 32,
   parameter int unsigned GRID_H = 32,
   parameter int unsigned CELL_W = 16,
   parameter int unsigned LANES  = 4,
   localparam int unsigned XW    = $clog2(GRID_W),
   localparam int unsigned YW    = $clog2(GRID_H),
   localparam int unsigned BW    = $clog2(BANKS),
   localparam int unsigned DEPTH = GRID_H * (GRID_W / BANKS),
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned PORTS = BANKS * lsq_pkg::PORTS_PER_BANK
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_en,
   input  logic [XW-1:0]           ld_x,
   input  logic [YW-1:0]           ld_y,
   input  logic [CELL_W-1:0]       ld_data,
   input  logic [LANES*XW-1:0]     map_x,
   input  logic [LANES*YW-1:0]     map_y,
   output logic [LANES*BW-1:0]     map_bank,
   output logic [LANES*AW-1:0]     map_addr,
   input  logic [PORTS-1:0]        rd_en,
   input  logic [PORTS*AW-1:0]     rd_addr,
   output logic [PORTS*CELL_W-1:0] rd_data,
   output logic [PORTS-1:0]        rd_valid
);
   localparam int unsigned NRD = lsq_pkg::PORTS_PER_BANK;

   // Elaboration-time parameter checks.
   generate
      if (BANKS < 2)             begin : g_bad_banks  $error("BANKS must be at least 2");           end
      if (GRID_W < BANKS)        begin : g_bad_w      $error("GRID_W must be at least BANKS");      end
      if (GRID_H < BANKS)        begin : g_bad_h      $error("GRID_H must be at least BANKS");      end
      if (GRID_W % BANKS != 0)   begin : g_bad_tile   $error("GRID_W must be a multiple of BANKS"); end
      if (CELL_W < 1)            begin : g_bad_cell   $error("CELL_W must be positive");            end
      if (LANES < 1)             begin : g_bad_lanes  $error("LANES must be positive");             end
   endgenerate

   // Load path: same mapping as the query lanes.
   logic [BW-1:0] ld_bank;
   logic [AW-1:0] ld_addr;

   lsq_addr_map #(.BANKS(BANKS), .GRID_W(GRID_W), .XW(XW), .YW(YW), .BW(BW), .AW(AW)) ld_map_i (
      .cell_x(ld_x), .cell_y(ld_y), .bank(ld_bank), .addr(ld_addr)
   );

   // Query lanes for the cores.
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         lsq_addr_map #(.BANKS(BANKS), .GRID_W(GRID_W), .XW(XW), .YW(YW), .BW(BW), .AW(AW)) map_i (
            .cell_x(map_x[l*XW +: XW]),
            .cell_y(map_y[l*YW +: YW]),
            .bank  (map_bank[l*BW +: BW]),
            .addr  (map_addr[l*AW +: AW])
         );
      end
   endgenerate

   // Bank array.
   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         logic bank_we;
         assign bank_we = ld_en && (ld_bank == BW'(b));

         lsq_bank #(.DEPTH(DEPTH), .AW(AW), .CELL_W(CELL_W), .NRD(NRD)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_we),
            .wr_addr (ld_addr),
            .wr_data (ld_data),
            .rd_en   (rd_en[b*NRD +: NRD]),
            .rd_addr (rd_addr[b*NRD*AW +: NRD*AW]),
            .rd_data (rd_data[b*NRD*CELL_W +: NRD*CELL_W]),
            .rd_valid(rd_valid[b*NRD +: NRD])
         );
      end
   endgenerate
endmodule

// File: rtl/lsq_grid_mem_chk.sv
// Property checker, attached to lsq_grid_mem by bind.
module lsq_grid_mem_chk #(
   parameter int unsigned BANKS  = 16,
   parameter int unsigned CELL_W = 16,
   parameter int unsigned LANES  = 4,
   parameter int unsigned XW     = 5,
   parameter int unsigned YW     = 5,
   parameter int unsigned BW     = 4
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                ld_en,
   input logic [LANES*XW-1:0]                 map_x,
   input logic [LANES*YW-1:0]                 map_y,
   input logic [LANES*BW-1:0]                 map_bank,
   input logic [2*BANKS-1:0]                  rd_en,
   input logic [2*BANKS-1:0]                  rd_valid,
   input logic [2*BANKS*CELL_W-1:0]           rd_data
);
   localparam int unsigned PORTS = 2 * BANKS;

   // R10: loading and reading never overlap (input contract).
   p_no_load_with_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |-> (rd_en == '0));

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         p_valid_after_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en[p] |=> rd_valid[p]);
         p_no_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en[p] |=> !rd_valid[p]);
         p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en[p] |=> $stable(rd_data[p*CELL_W +: CELL_W]));
      end

      if (LANES >= 2) begin : g_pair
         int dx, dy;
         logic [XW-1:0] x0, x1;
         logic [YW-1:0] y0, y1;
         assign x0 = map_x[0 +: XW];
         assign x1 = map_x[XW +: XW];
         assign y0 = map_y[0 +: YW];
         assign y1 = map_y[YW +: YW];
         always_comb begin
            dx = (x0 > x1) ? int'(x0 - x1) : int'(x1 - x0);
            dy = (y0 > y1) ? int'(y0 - y1) : int'(y1 - y0);
         end
         p_row_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (y0 == y1 && x0 != x1 && dx < int'(BANKS)) |-> (map_bank[0 +: BW] != map_bank[BW +: BW]));
         p_col_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (x0 == x1 && y0 != y1 && dy < int'(BANKS)) |-> (map_bank[0 +: BW] != map_bank[BW +: BW]));
      end
   endgenerate
endmodule

bind lsq_grid_mem lsq_grid_mem_chk #(
   .BANKS(BANKS), .CELL_W(CELL_W), .LANES(LANES), .XW(XW), .YW(YW), .BW(BW)
) chk_i (.*);

// File: tb/lsq_grid_mem_tb_top.sv
module lsq_grid_mem_tb_top;
   localparam int B = 16, W = 32, H = 32, CW = 16, LN = 4;
   localparam int XW = 5, YW = 5, BW = 4, COLS = W / B, DEPTH = H * COLS, AW = 6, P = 2 * B;
   localparam int WATCHDOG = 100000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ld_en = 1'b0;
   logic [XW-1:0] ld_x = '0;
   logic [YW-1:0] ld_y = '0;
   logic [CW-1:0] ld_data = '0;
   logic [LN*XW-1:0] map_x = '0;
   logic [LN*YW-1:0] map_y = '0;
   logic [LN*BW-1:0] map_bank;
   logic [LN*AW-1:0] map_addr;
   logic [P-1:0] rd_en = '0;
   logic [P*AW-1:0] rd_addr = '0;
   logic [P*CW-1:0] rd_data;
   logic [P-1:0] rd_valid;

   lsq_grid_mem #(.BANKS(B), .GRID_W(W), .GRID_H(H), .CELL_W(CW), .LANES(LN)) dut_i (.*);

   always #10 clk = ~clk;   // 50 MHz

   int cyc = 0, total = 0, bad = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Reference model, built from the requirements.
   logic [CW-1:0] model [H][W];
   logic [CW-1:0] last  [P];
   int bk [H][W];

   function automatic int ref_bank(input int x, input int y); return (x + y) % B; endfunction
   function automatic int ref_addr(input int x, input int y); return y * COLS + x / B; endfunction
   function automatic int inv_x(input int b, input int a);
      int y = a / COLS;
      return (a % COLS) * B + ((b - (y % B) + B) % B);
   endfunction

   typedef struct { int due; int port; bit req; logic [CW-1:0] data; } sb_t;
   sb_t sbq[$];

   // Monitor: compares due items at the falling edge.
   always @(negedge clk) begin
      sb_t it;
      while (sbq.size() > 0 && sbq[0].due == cyc) begin
         it = sbq.pop_front();
         if (it.req) begin
            chk(rd_valid[it.port] == 1'b1, "R5", $sformatf("valid port %0d", it.port), int'(rd_valid[it.port]), 1);
            chk(rd_data[it.port*CW +: CW] == it.data, "R5", $sformatf("data port %0d", it.port),
                int'(rd_data[it.port*CW +: CW]), int'(it.data));
         end else begin
            chk(rd_valid[it.port] == 1'b0, "R6", $sformatf("idle valid port %0d", it.port), int'(rd_valid[it.port]), 0);
            chk(rd_data[it.port*CW +: CW] == it.data, "R8", $sformatf("hold port %0d", it.port),
                int'(rd_data[it.port*CW +: CW]), int'(it.data));
         end
      end
   end

   task automatic load_cell(input int x, input int y, input logic [CW-1:0] d);
      @(negedge clk); #1;
      rd_en = '0; ld_en = 1'b1; ld_x = XW'(x); ld_y = YW'(y); ld_data = d;
      model[y][x] = d;
   endtask

   // One read cycle: en/addr per port; pushes expected results.
   task automatic read_cycle(input logic [P-1:0] en, input int addrs [P]);
      @(negedge clk); #1;
      ld_en = 1'b0;
      for (int p = 0; p < P; p++) begin
         sb_t it;
         rd_en[p] = en[p];
         rd_addr[p*AW +: AW] = AW'(addrs[p]);
         it.due = cyc + 1; it.port = p; it.req = en[p];
         if (en[p]) begin
            int a = addrs[p];
            int x = inv_x(p / 2, a);
            last[p] = model[a / COLS][x];
         end
         it.data = last[p];
         sbq.push_back(it);
      end
   endtask

   task automatic idle_cycle();
      int z [P];
      for (int p = 0; p < P; p++) z[p] = 0;
      read_cycle('0, z);
   endtask

   initial begin : watchdog
      wait (cyc == WATCHDOG);
      chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      int addrs [P];
      for (int p = 0; p < P; p++) last[p] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state (R6)
      chk(rd_valid == '0, "R6", "valid after reset", int'(rd_valid[15:0]), 0);
      chk(rd_data == '0, "R6", "data after reset", int'(rd_data[15:0]), 0);

      // Mapping lanes (R1, R2), neighbours on lanes 0/1 for R3 properties
      for (int y = 0; y < H; y++) begin
         for (int x = 0; x < W; x++) begin
            int lx [LN], ly [LN];
            @(negedge clk); #1;
            lx[0] = x; ly[0] = y;
            if ((x + y) % 2 == 0) begin lx[1] = (x + 1) % W; ly[1] = y; end
            else begin lx[1] = x; ly[1] = (y + 1) % H; end
            lx[2] = (x + 5) % W; ly[2] = y;
            lx[3] = W - 1 - x;   ly[3] = H - 1 - y;
            for (int l = 0; l < LN; l++) begin
               map_x[l*XW +: XW] = XW'(lx[l]);
               map_y[l*YW +: YW] = YW'(ly[l]);
            end
            #2;
            for (int l = 0; l < LN; l++) begin
               chk(int'(map_bank[l*BW +: BW]) == ref_bank(lx[l], ly[l]), "R1", "lane bank",
                   int'(map_bank[l*BW +: BW]), ref_bank(lx[l], ly[l]));
               chk(int'(map_addr[l*AW +: AW]) == ref_addr(lx[l], ly[l]), "R2", "lane addr",
                   int'(map_addr[l*AW +: AW]), ref_addr(lx[l], ly[l]));
            end
            bk[y][x] = int'(map_bank[0 +: BW]);
         end
      end

      // R3: row and column windows of width B hold distinct banks
      for (int y = 0; y < H; y++) begin
         int clash = 0;
         for (int x0 = 0; x0 < W; x0++)
            for (int x1 = x0 + 1; x1 < W && x1 - x0 < B; x1++)
               if (bk[y][x0] == bk[y][x1]) clash++;
         chk(clash == 0, "R3", $sformatf("row %0d clashes", y), clash, 0);
      end
      for (int x = 0; x < W; x++) begin
         int clash = 0;
         for (int y0 = 0; y0 < H; y0++)
            for (int y1 = y0 + 1; y1 < H && y1 - y0 < B; y1++)
               if (bk[y0][x] == bk[y1][x]) clash++;
         chk(clash == 0, "R3", $sformatf("column %0d clashes", x), clash, 0);
      end

      // Load the full grid (R4, R10: loads on their own cycles)
      for (int y = 0; y < H; y++)
         for (int x = 0; x < W; x++)
            load_cell(x, y, CW'((x * 37 + y * 101) ^ 16'h5A5A));

      // Read back everything, the two sides of a bank on different addresses (R4, R5, R7)
      for (int a = 0; a < DEPTH; a++) begin
         for (int b = 0; b < B; b++) begin
            addrs[2*b]     = a;
            addrs[2*b + 1] = (a * 7 + 3 + b) % DEPTH;
         end
         read_cycle('1, addrs);
      end

      // R7: both sides of every bank on the same address
      for (int b = 0; b < B; b++) begin addrs[2*b] = b + 9; addrs[2*b + 1] = b + 9; end
      read_cycle('1, addrs);

      // R8/R6: idle cycles hold data with valid low; then only odd ports read
      idle_cycle();
      idle_cycle();
      for (int b = 0; b < B; b++) begin addrs[2*b] = 0; addrs[2*b + 1] = DEPTH - 1 - b; end
      read_cycle({B{2'b10}}, addrs);
      idle_cycle();

      // R9: load inputs change with enable low; cell (3,4) must keep its value
      @(negedge clk); #1;
      rd_en = '0; ld_en = 1'b0; ld_x = XW'(3); ld_y = YW'(4); ld_data = 16'hDEAD;
      @(negedge clk); #1;
      ld_x = XW'(5); ld_y = YW'(7); ld_data = 16'h1111;
      for (int p = 0; p < P; p++) addrs[p] = 0;
      addrs[2*ref_bank(3, 4)] = ref_addr(3, 4);
      read_cycle(P'(1) << (2*ref_bank(3, 4)), addrs);   // R9 check via scoreboard

      // R4: overwrite one cell and read it on side B of its bank
      load_cell(5, 7, 16'hBEEF);
      for (int p = 0; p < P; p++) addrs[p] = 0;
      addrs[2*ref_bank(5, 7) + 1] = ref_addr(5, 7);
      read_cycle(P'(1) << (2*ref_bank(5, 7) + 1), addrs);
      idle_cycle();
      idle_cycle();

      repeat (2) @(negedge clk);
      chk(sbq.size() == 0, "R5", "scoreboard drained", sbq.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule